// File: doc/BRIEF.md
# Accumulator-Clocked Noise LFSR

This block is the noise source of one oscillator voice. It holds a 23-bit linear feedback shift register (LFSR). The register does not advance on every clock. It advances once each time a watched bit of the voice's phase accumulator goes from 0 to 1, and each advance lands a fixed number of clocks after that edge. The default delay is two clocks.

Eight scattered register bits form the top byte of a 12-bit noise sample, and the four lowest bits of the sample are held at zero. The test control enters the feedback term as an OR with the top register bit. While test is held, the accumulator that feeds this block stands still, so no new rising edges arrive. An advance that is already pending still completes.

Top module: `noise_lfsr`

## Requirements
- R1: While `rst_n` is low, the register is loaded with all ones. Right after reset, `noise_o` reads 12'hFF0.
- R2: Each advance replaces the register with `{old[21:0], (old[22] | test_i) ^ old[17]}`.
- R3: A rising edge is seen at a clock edge where `acc_b19_i` is 1 and was 0 at the previous clock edge. The advance is applied at the second clock edge after the edge that saw the rise, and `noise_o` shows the new value just after that second edge.
- R4: Each rising edge gives exactly one advance. While `acc_b19_i` stays at 1, or stays at 0, the register does not change apart from an advance already pending.
- R5: A new rising edge seen while an advance is pending cancels that advance and starts the full delay again. It does so even at the clock edge where the pending advance would otherwise have taken place.
- R6: `noise_o[11:4]` equals register bits 20, 18, 14, 11, 9, 5, 2 and 0, with bit 20 at `noise_o[11]`.
- R7: `noise_o[3:0]` is always 0.
- R8: A raised `test_i` with no rising edge does not advance the register. If `test_i` is 1 at the clock edge of a pending advance, the new bit 0 is `1 ^ old[17]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_i | input | 1 | Test control, ORed into the feedback term |
| acc_b19_i | input | 1 | Level of the watched phase-accumulator bit |
| noise_o | output | 12 | Noise sample: eight taps in the top bits, zeros in the low four |

## Verification
The register is visible only through the eight output taps. A wrong feedback bit therefore first shows as a change in `noise_o[4]` after the advance that creates it. Over later advances the wrong bit moves up through the higher taps.

A wrong delay or a missed retrigger shows at the ports as a sample that changes one clock early, one clock late, or at an edge where it should not change. The bench compares the output against its model on every clock, so a timing fault of this kind is caught within the clock it occurs. A state fault is caught within a few advances, before the wrong bit has moved past all the taps.

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int SHIFT_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        test_i,
  input  logic        acc_b19_i,
  output logic [11:0] noise_o
);
  localparam int LW = 23;
  localparam int CW = $clog2(SHIFT_DELAY + 1);
  localparam logic [CW-1:0] ARM  = CW'(SHIFT_DELAY);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [LW-1:0] lfsr;
  logic [CW-1:0] cnt;
  logic          b19_q;
  logic          rise;
  logic          fire;
  logic          fb;

  assign rise = acc_b19_i & ~b19_q;
  assign fire = ~rise & (cnt == LAST);
  assign fb   = (lfsr[22] | test_i) ^ lfsr[17];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr  <= '1;
      cnt   <= '0;
      b19_q <= 1'b0;
    end else begin
      b19_q <= acc_b19_i;
      if (rise)
        cnt <= ARM;
      else if (cnt != '0)
        cnt <= cnt - LAST;
      if (fire)
        lfsr <= {lfsr[LW-2:0], fb};
    end
  end

  assign noise_o = {lfsr[20], lfsr[18], lfsr[14], lfsr[11],
                    lfsr[9], lfsr[5], lfsr[2], lfsr[0], 4'b0000};

  assert_step_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr != $past(lfsr)) |->
      lfsr == {$past(lfsr[21:0]), ($past(lfsr[22]) | $past(test_i)) ^ $past(lfsr[17])});

  assert_step_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr != $past(lfsr)) |-> ($past(cnt) == LAST));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> $stable(lfsr));

  assert_retrigger_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST && rise) |=> ($stable(lfsr) && cnt == ARM));
endmodule

// File: tb/noise_lfsr_tb_top.sv
`timescale 1ns/1ps
module noise_lfsr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_i = 1'b0;
  logic acc_b19_i = 1'b0;
  logic [11:0] noise_o;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  noise_lfsr dut_i (.clk(clk), .rst_n(rst_n), .test_i(test_i),
                    .acc_b19_i(acc_b19_i), .noise_o(noise_o));

  logic [22:0] m;
  int cyc;
  int due;
  logic prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 23'h7FFFFF; cyc = 0; due = -1; prev = 1'b0;
    end else begin
      cyc = cyc + 1;
      if (acc_b19_i && !prev) due = cyc + 2;
      else if (cyc == due) m = {m[21:0], (m[22] | test_i) ^ m[17]};
      prev = acc_b19_i;
    end
  end

  function automatic logic [11:0] taps(input logic [22:0] r);
    return {r[20], r[18], r[14], r[11], r[9], r[5], r[2], r[0], 4'b0000};
  endfunction

  task automatic chk(input string t, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s noise_o got %h expected %h", t, got, exp);
    end
  endtask

  task automatic cyc1(input logic b, input logic t);
    acc_b19_i = b; test_i = t;
    @(negedge clk);
    chk(tag, noise_o, taps(m));
    chk("R7", {8'h00, noise_o[3:0]}, 12'h000);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", noise_o, 12'hFF0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", noise_o, 12'hFF0);

    tag = "R3";
    cyc1(1'b1, 1'b0); chk("R3", noise_o, 12'hFF0);
    cyc1(1'b1, 1'b0); chk("R3", noise_o, 12'hFF0);
    cyc1(1'b1, 1'b0); chk("R3", noise_o, 12'hFE0);

    tag = "R4";
    for (int i = 0; i < 20; i++) cyc1(1'b1, 1'b0);
    chk("R4", noise_o, 12'hFE0);
    for (int i = 0; i < 20; i++) cyc1(1'b0, 1'b0);
    chk("R4", noise_o, 12'hFE0);

    tag = "R5";
    for (int i = 0; i < 30; i++) cyc1(i[0] ? 1'b0 : 1'b1, 1'b0);
    chk("R5", noise_o, 12'hFE0);
    cyc1(1'b0, 1'b0); cyc1(1'b0, 1'b0);
    chk("R5", noise_o, taps(m));

    tag = "R8";
    for (int i = 0; i < 15; i++) cyc1(1'b0, 1'b1);
    chk("R8", noise_o, taps(m));

    tag = "R2/R6";
    for (int i = 0; i < 4000; i++) cyc1((i % 8) >= 4, 1'b0);
    for (int i = 0; i < 4000; i++) cyc1((i % 5) >= 2, 1'b0);

    tag = "R8 with R2";
    for (int i = 0; i < 4000; i++) cyc1(1'($urandom), 1'($urandom));

    tag = "R5 random";
    for (int i = 0; i < 4000; i++) cyc1(1'($urandom_range(0, 3) != 0), 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule